// File: doc/BRIEF.md
# Reuse-Counter Replication Decision Unit

This block is the policy engine for one directory entry of a banked, shared last-level cache. It decides when a cache line has been reused often enough by one core at its home bank to justify placing a private copy in that core's nearby bank group. It also decides when a core should lose that copy status again. For each core it keeps a small saturating owner-bank reuse counter and a copy-sharer flag. For the entry as a whole it keeps a replica reuse counter and a replication indicator.

The surrounding controller presents at most one event per cycle, tagged with the core it concerns. There are five event kinds: a read hit at the home bank, a hit on the local replica, a write reaching the home bank (presented after all invalidation acknowledgements have returned), an invalidation acknowledgement that carries the replica's reuse count, and a replica eviction acknowledgement that carries the same count. One cycle after each event the block presents a registered decision: create a replica for the core, demote the core, or keep its status. The full counter and flag state is also visible at the ports.

Top module: `rcr_unit`

## Requirements
- R1: After reset every owner counter, every copy flag, the replica counter, the indicator and `dec_valid` are 0.
- R2: A home-bank read (kind 0) from core c whose owner counter is below THRESH increments that counter. It creates no replica and leaves the copy flags alone.
- R3: A home-bank read from core c whose counter is at or above THRESH, with `evt_local_owner` low, raises `dec_create` with `dec_core`=c. It sets copy flag c and the indicator, sets counter c to 1 and clears the replica counter.
- R4: The same read with `evt_local_owner` high sets the indicator only. There is no create, counter c is unchanged and copy flag c is unchanged.
- R5: A replica hit (kind 1) from a copy sharer increments the replica counter and saturates it at 2^CW-1. A replica hit from a core that is not a copy sharer changes nothing.
- R6: A write (kind 2) from core c clears every other core's owner counter. Core c's counter is set to 1, or, when `evt_single_sharer` is high, it is incremented with saturation.
- R7: An invalidation acknowledgement (kind 3) for copy sharer c keeps copy status when counter c plus `evt_reuse` is greater than THRESH. Otherwise it demotes core c (`dec_demote`=1, copy flag cleared). The replica counter is cleared in both cases.
- R8: A replica eviction acknowledgement (kind 4) for copy sharer c keeps copy status when `evt_reuse` is at least THRESH. Otherwise it demotes core c. The replica counter is cleared.
- R9: The indicator is cleared when the last copy sharer is demoted. While any copy flag is set, the indicator is set.
- R10: `dec_valid` is high for exactly the one cycle after each accepted event. An event with an unused kind code (5 to 7) or an out-of-range core changes no state and gives no decision.
- R11: Owner counters saturate at 2^CW-1 and never wrap, where CW = clog2(THRESH+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 3 | 0 home read, 1 replica hit, 2 write, 3 invalidation ack, 4 eviction ack |
| evt_core | input | CORE_W | Core the event concerns |
| evt_local_owner | input | 1 | Home bank lies in the requester's local bank group |
| evt_single_sharer | input | 1 | Writer is the only sharer of the line |
| evt_reuse | input | CW | Replica reuse count carried by an acknowledgement |
| dec_valid | output | 1 | Decision below is valid (one cycle after the event) |
| dec_create | output | 1 | Insert a replica for `dec_core` |
| dec_demote | output | 1 | `dec_core` loses copy status |
| dec_keep | output | 1 | `dec_core` is a copy sharer after the event |
| dec_core | output | CORE_W | Core the decision concerns |
| own_cnt | output | NUM_CORES*CW | Owner counters, core i at bits [i*CW +: CW] |
| copy_vec | output | NUM_CORES | Copy-sharer flags, bit i for core i |
| rep_cnt | output | CW | Replica reuse counter |
| rib | output | 1 | Replication indicator |

## Verification
The bench drives a counter exactly to THRESH and then once more, because an off-by-one in the threshold compare would replicate a read too early or too late. The invalidation case uses a sum exactly equal to THRESH, where a `>=` compare would wrongly keep the core. The eviction case uses reuse at THRESH and one below, where a strict compare would wrongly demote. It also saturates the replica and owner counters, which would read back small values if they wrapped. It makes sure writes from a shared writer reset the writer to 1 rather than increment it. It checks that a home bank inside the local group never raises a create, and that an unused kind code neither moves a counter nor pulses `dec_valid`.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [2:0] {
    EV_OWNER_RD  = 3'd0,
    EV_REP_HIT   = 3'd1,
    EV_WRITE     = 3'd2,
    EV_INV_ACK   = 3'd3,
    EV_REP_EVICT = 3'd4
  } evt_kind_e;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_ONE  = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;

  typedef enum logic [1:0] {
    CP_HOLD = 2'd0,
    CP_SET  = 2'd1,
    CP_CLR  = 2'd2
  } copy_op_e;

  // saturating increment toward maxv
  function automatic int sat_inc(input int v, input int maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  // invalidation ack: owner reuse plus replica reuse must exceed the threshold
  function automatic logic keep_after_inv(input int own, input int reuse, input int thr);
    return (own + reuse) > thr;
  endfunction

  // replica eviction: replica reuse alone must reach the threshold
  function automatic logic keep_after_evict(input int reuse, input int thr);
    return reuse >= thr;
  endfunction

  // home-bank read qualifies for replication
  function automatic logic reached_thr(input int own, input int thr);
    return own >= thr;
  endfunction

endpackage

// File: rtl/rcr_core_slot.sv
module rcr_core_slot
  import rcr_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_op_e       cnt_op,
  input  copy_op_e      copy_op,
  output logic [CW-1:0] cnt_q,
  output logic          copy_q
);
  localparam int MAXV = (1 << CW) - 1;

  logic [CW-1:0] cnt_d;
  logic          copy_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (cnt_op)
      CNT_INC:  cnt_d = CW'(sat_inc(int'(cnt_q), MAXV));
      CNT_ONE:  cnt_d = CW'(1);
      CNT_ZERO: cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_comb begin
    copy_d = copy_q;
    case (copy_op)
      CP_SET:  copy_d = 1'b1;
      CP_CLR:  copy_d = 1'b0;
      default: copy_d = copy_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      copy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      copy_q <= copy_d;
    end
  end
endmodule

// File: rtl/rcr_replica_track.sv
module rcr_replica_track
  import rcr_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rep_inc,
  input  logic          rep_clr,
  input  logic          rib_set,
  input  logic          rib_clr,
  output logic [CW-1:0] rep_q,
  output logic          rib_q
);
  localparam int MAXV = (1 << CW) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q <= '0;
      rib_q <= 1'b0;
    end else begin
      if (rep_clr)      rep_q <= '0;
      else if (rep_inc) rep_q <= CW'(sat_inc(int'(rep_q), MAXV));
      if (rib_set)      rib_q <= 1'b1;
      else if (rib_clr) rib_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rcr_decide.sv
module rcr_decide
  import rcr_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int THRESH    = 4,
  parameter int CW        = 3,
  parameter int CORE_W    = 3
) (
  input  logic                 ev_rd,
  input  logic                 ev_hit,
  input  logic                 ev_wr,
  input  logic                 ev_inv,
  input  logic                 ev_evict,
  input  logic [CORE_W-1:0]    sel,
  input  logic                 local_owner,
  input  logic                 single_sharer,
  input  logic [CW-1:0]        reuse,
  input  logic [CW-1:0]        sel_cnt,
  input  logic [NUM_CORES-1:0] copy_vec,
  output cnt_op_e              cnt_op  [NUM_CORES],
  output copy_op_e             copy_op [NUM_CORES],
  output logic                 rep_inc,
  output logic                 rep_clr,
  output logic                 rib_set,
  output logic                 rib_clr,
  output logic                 create,
  output logic                 demote,
  output logic                 keep
);
  logic                 sel_copy;
  logic                 rd_over;
  logic                 ack_keep;
  logic [NUM_CORES-1:0] others_copy;

  always_comb begin
    sel_copy    = 1'b0;
    others_copy = copy_vec;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (CORE_W'(i) == sel) begin
        sel_copy       = copy_vec[i];
        others_copy[i] = 1'b0;
      end
    end
  end

  assign rd_over  = ev_rd && reached_thr(int'(sel_cnt), THRESH);
  assign ack_keep = ev_inv ? keep_after_inv(int'(sel_cnt), int'(reuse), THRESH)
                           : keep_after_evict(int'(reuse), THRESH);

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      cnt_op[i]  = CNT_HOLD;
      copy_op[i] = CP_HOLD;
    end
    rep_inc = 1'b0;
    rep_clr = 1'b0;
    rib_set = 1'b0;
    rib_clr = 1'b0;
    create  = 1'b0;
    demote  = 1'b0;
    keep    = sel_copy;

    for (int i = 0; i < NUM_CORES; i++) begin
      if (CORE_W'(i) == sel) begin
        if (ev_rd) begin
          if (rd_over) begin
            rib_set = 1'b1;
            if (!local_owner) begin
              cnt_op[i]  = CNT_ONE;
              copy_op[i] = CP_SET;
              rep_clr    = 1'b1;
              create     = 1'b1;
              keep       = 1'b1;
            end
          end else begin
            cnt_op[i] = CNT_INC;
          end
        end
        if (ev_wr) cnt_op[i] = single_sharer ? CNT_INC : CNT_ONE;
        if ((ev_inv || ev_evict) && sel_copy && !ack_keep) begin
          copy_op[i] = CP_CLR;
          demote     = 1'b1;
          keep       = 1'b0;
        end
      end else if (ev_wr) begin
        cnt_op[i] = CNT_ZERO;
      end
    end

    if (ev_hit && sel_copy) rep_inc = 1'b1;
    if (ev_inv || ev_evict) rep_clr = 1'b1;
    if (demote && (others_copy == '0)) rib_clr = 1'b1;
  end
endmodule

// File: rtl/rcr_unit.sv
module rcr_unit
  import rcr_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int THRESH    = 4,
  localparam int CW       = $clog2(THRESH + 1),
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic [2:0]              evt_kind,
  input  logic [CORE_W-1:0]       evt_core,
  input  logic                    evt_local_owner,
  input  logic                    evt_single_sharer,
  input  logic [CW-1:0]           evt_reuse,
  output logic                    dec_valid,
  output logic                    dec_create,
  output logic                    dec_demote,
  output logic                    dec_keep,
  output logic [CORE_W-1:0]       dec_core,
  output logic [NUM_CORES*CW-1:0] own_cnt,
  output logic [NUM_CORES-1:0]    copy_vec,
  output logic [CW-1:0]           rep_cnt,
  output logic                    rib
);
  // named internal events
  logic core_ok, ev_rd, ev_hit, ev_wr, ev_inv, ev_evict, ev_any;

  assign core_ok  = int'(evt_core) < NUM_CORES;
  assign ev_rd    = evt_valid && core_ok && (evt_kind == EV_OWNER_RD);
  assign ev_hit   = evt_valid && core_ok && (evt_kind == EV_REP_HIT);
  assign ev_wr    = evt_valid && core_ok && (evt_kind == EV_WRITE);
  assign ev_inv   = evt_valid && core_ok && (evt_kind == EV_INV_ACK);
  assign ev_evict = evt_valid && core_ok && (evt_kind == EV_REP_EVICT);
  assign ev_any   = ev_rd || ev_hit || ev_wr || ev_inv || ev_evict;

  logic [CW-1:0] cnt_arr [NUM_CORES];
  logic [CW-1:0] sel_cnt;
  cnt_op_e       cnt_op  [NUM_CORES];
  copy_op_e      copy_op [NUM_CORES];
  logic rep_inc, rep_clr, rib_set, rib_clr;
  logic create_c, demote_c, keep_c;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (CORE_W'(i) == evt_core) sel_cnt = cnt_arr[i];
  end

  rcr_decide #(
    .NUM_CORES(NUM_CORES), .THRESH(THRESH), .CW(CW), .CORE_W(CORE_W)
  ) u_decide (
    .ev_rd        (ev_rd),
    .ev_hit       (ev_hit),
    .ev_wr        (ev_wr),
    .ev_inv       (ev_inv),
    .ev_evict     (ev_evict),
    .sel          (evt_core),
    .local_owner  (evt_local_owner),
    .single_sharer(evt_single_sharer),
    .reuse        (evt_reuse),
    .sel_cnt      (sel_cnt),
    .copy_vec     (copy_vec),
    .cnt_op       (cnt_op),
    .copy_op      (copy_op),
    .rep_inc      (rep_inc),
    .rep_clr      (rep_clr),
    .rib_set      (rib_set),
    .rib_clr      (rib_clr),
    .create       (create_c),
    .demote       (demote_c),
    .keep         (keep_c)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    rcr_core_slot #(.CW(CW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_op (cnt_op[g]),
      .copy_op(copy_op[g]),
      .cnt_q  (cnt_arr[g]),
      .copy_q (copy_vec[g])
    );
    assign own_cnt[g*CW +: CW] = cnt_arr[g];
  end

  rcr_replica_track #(.CW(CW)) u_rep (
    .clk    (clk),
    .rst_n  (rst_n),
    .rep_inc(rep_inc),
    .rep_clr(rep_clr),
    .rib_set(rib_set),
    .rib_clr(rib_clr),
    .rep_q  (rep_cnt),
    .rib_q  (rib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_create <= 1'b0;
      dec_demote <= 1'b0;
      dec_keep   <= 1'b0;
      dec_core   <= '0;
    end else begin
      dec_valid  <= ev_any;
      dec_create <= ev_any && create_c;
      dec_demote <= ev_any && demote_c;
      dec_keep   <= ev_any && keep_c;
      if (ev_any) dec_core <= evt_core;
    end
  end
endmodule

// File: rtl/rcr_unit_chk.sv
module rcr_unit_chk #(
  parameter int NUM_CORES = 8,
  parameter int CW        = 3,
  parameter int CORE_W    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    evt_valid,
  input logic                    ev_wr,
  input logic [CORE_W-1:0]       evt_core,
  input logic                    dec_valid,
  input logic                    dec_create,
  input logic                    dec_demote,
  input logic [CORE_W-1:0]       dec_core,
  input logic [NUM_CORES*CW-1:0] own_cnt,
  input logic [NUM_CORES-1:0]    copy_vec,
  input logic [CW-1:0]           rep_cnt,
  input logic                    rib
);
  logic              wr_seen;
  logic [CORE_W-1:0] wr_core;
  logic              others_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      wr_core <= '0;
    end else begin
      wr_seen <= ev_wr;
      wr_core <= evt_core;
    end
  end

  always_comb begin
    others_zero = 1'b1;
    for (int i = 0; i < NUM_CORES; i++)
      if (CORE_W'(i) != wr_core && own_cnt[i*CW +: CW] != '0) others_zero = 1'b0;
  end

  // R10
  dec_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(evt_valid));

  // R3
  create_sets_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_create |-> copy_vec[dec_core]);

  // R7
  demote_clears_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_demote |-> !copy_vec[dec_core]);

  // R8
  create_demote_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_create, dec_demote}));

  // R9
  copy_implies_rib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_vec != '0) |-> rib);

  // R6
  write_clears_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |-> others_zero);

  // R5
  rep_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(rep_cnt));
endmodule

bind rcr_unit rcr_unit_chk #(
  .NUM_CORES(NUM_CORES), .CW(CW), .CORE_W(CORE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .ev_wr     (ev_wr),
  .evt_core  (evt_core),
  .dec_valid (dec_valid),
  .dec_create(dec_create),
  .dec_demote(dec_demote),
  .dec_core  (dec_core),
  .own_cnt   (own_cnt),
  .copy_vec  (copy_vec),
  .rep_cnt   (rep_cnt),
  .rib       (rib)
);

// File: tb/sim_rcr_unit.sv
module sim_rcr_unit;
  localparam int N  = 8;
  localparam int TH = 4;
  localparam int CW = 3;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [2:0]    evt_kind = '0;
  logic [KW-1:0] evt_core = '0;
  logic          evt_local_owner = 1'b0;
  logic          evt_single_sharer = 1'b0;
  logic [CW-1:0] evt_reuse = '0;
  logic          dec_valid, dec_create, dec_demote, dec_keep;
  logic [KW-1:0] dec_core;
  logic [N*CW-1:0] own_cnt;
  logic [N-1:0]  copy_vec;
  logic [CW-1:0] rep_cnt;
  logic          rib;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  rcr_unit #(.NUM_CORES(N), .THRESH(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_core(evt_core), .evt_local_owner(evt_local_owner),
    .evt_single_sharer(evt_single_sharer), .evt_reuse(evt_reuse),
    .dec_valid(dec_valid), .dec_create(dec_create), .dec_demote(dec_demote),
    .dec_keep(dec_keep), .dec_core(dec_core), .own_cnt(own_cnt),
    .copy_vec(copy_vec), .rep_cnt(rep_cnt), .rib(rib)
  );

  function automatic int cnt_of(input int c);
    return int'(own_cnt[c*CW +: CW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one event: driven at a falling edge, result sampled at the next falling edge
  task automatic ev(input int k, input int c, input bit loc, input bit sg, input int r);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_kind = 3'(k);
    evt_core = KW'(c);
    evt_local_owner = loc;
    evt_single_sharer = sg;
    evt_reuse = CW'(r);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 own_cnt", int'(own_cnt), 0);
    chk("R1 copy_vec", int'(copy_vec), 0);
    chk("R1 rep_cnt", int'(rep_cnt), 0);
    chk("R1 rib", int'(rib), 0);
    chk("R1 dec_valid", int'(dec_valid), 0);
  endtask

  task automatic t_read_ramp();
    for (int i = 1; i <= 4; i++) begin
      ev(0, 2, 0, 0, 0);
      chk("R2 count", cnt_of(2), i);
      chk("R2 no create", int'(dec_create), 0);
      chk("R2 copy", int'(copy_vec), 0);
    end
  endtask

  task automatic t_replicate();
    ev(0, 2, 0, 0, 0);
    chk("R3 create", int'(dec_create), 1);
    chk("R3 core", int'(dec_core), 2);
    chk("R3 copy", int'(copy_vec), 'h04);
    chk("R3 count reset", cnt_of(2), 1);
    chk("R3 rib", int'(rib), 1);
    chk("R3 rep cleared", int'(rep_cnt), 0);
  endtask

  task automatic t_rep_hits();
    ev(1, 5, 0, 0, 0);
    chk("R5 non-copy hit ignored", int'(rep_cnt), 0);
    for (int i = 0; i < 3; i++) ev(1, 2, 0, 0, 0);
    chk("R5 hits counted", int'(rep_cnt), 3);
    for (int i = 0; i < 6; i++) ev(1, 2, 0, 0, 0);
    chk("R5 saturate", int'(rep_cnt), 7);
  endtask

  task automatic t_inv_ack();
    ev(3, 2, 0, 0, 3);  // 1 + 3 = 4, not above threshold
    chk("R7 demote", int'(dec_demote), 1);
    chk("R7 copy cleared", int'(copy_vec), 0);
    chk("R7 rep cleared", int'(rep_cnt), 0);
    chk("R9 rib cleared", int'(rib), 0);
    for (int i = 0; i < 3; i++) ev(0, 2, 0, 0, 0);
    ev(0, 2, 0, 0, 0);
    chk("R3 re-create", int'(dec_create), 1);
    ev(3, 2, 0, 0, 4);  // 1 + 4 = 5, above threshold
    chk("R7 no demote", int'(dec_demote), 0);
    chk("R7 keep", int'(dec_keep), 1);
    chk("R7 copy kept", int'(copy_vec), 'h04);
    chk("R9 rib kept", int'(rib), 1);
  endtask

  task automatic t_evict();
    ev(4, 2, 0, 0, 4);
    chk("R8 keep at threshold", int'(dec_keep), 1);
    chk("R8 copy kept", int'(copy_vec), 'h04);
    ev(4, 2, 0, 0, 3);
    chk("R8 demote below", int'(dec_demote), 1);
    chk("R8 copy cleared", int'(copy_vec), 0);
    chk("R9 rib cleared", int'(rib), 0);
  endtask

  task automatic t_write();
    for (int i = 0; i < 2; i++) ev(0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) ev(0, 1, 0, 0, 0);
    chk("R2 setup c1", cnt_of(1), 3);
    ev(2, 1, 0, 0, 0);
    chk("R6 shared writer to 1", cnt_of(1), 1);
    chk("R6 other c0 cleared", cnt_of(0), 0);
    chk("R6 other c2 cleared", cnt_of(2), 0);
    ev(2, 1, 0, 1, 0);
    chk("R6 single writer inc", cnt_of(1), 2);
  endtask

  task automatic t_local_owner();
    for (int i = 0; i < 4; i++) ev(0, 3, 1, 0, 0);
    chk("R2 local ramp", cnt_of(3), 4);
    ev(0, 3, 1, 0, 0);
    chk("R4 no create", int'(dec_create), 0);
    chk("R4 rib set", int'(rib), 1);
    chk("R4 copy unchanged", int'(copy_vec), 0);
    chk("R4 count unchanged", cnt_of(3), 4);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 9; i++) ev(2, 6, 0, 1, 0);
    chk("R11 owner saturate", cnt_of(6), 7);
    chk("R6 c3 cleared", cnt_of(3), 0);
  endtask

  task automatic t_timing();
    ev(0, 7, 0, 0, 0);
    chk("R10 valid after event", int'(dec_valid), 1);
    @(negedge clk);
    chk("R10 valid drops", int'(dec_valid), 0);
    ev(7, 6, 0, 0, 0);
    chk("R10 bad kind no decision", int'(dec_valid), 0);
    chk("R10 bad kind no change", cnt_of(6), 7);
    chk("R10 bad kind c7", cnt_of(7), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ramp();
    t_replicate();
    t_rep_hits();
    t_inv_ack();
    t_evict();
    t_write();
    t_local_owner();
    t_saturate();
    t_timing();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule